// File: doc/BRIEF.md
# Watchdog Timer with Selectable Period

This block catches a program that has stopped making progress. After software arms it, a counter advances at a rate derived from the main clock. If software does not re-arm it before the selected interval runs out, the block raises either a system reset request or a non-maskable interrupt request. Software picks which one when it arms the block.

A free-running prescaler divides the main clock. A 3-bit period code picks one prescaler bit, and each rising edge of that bit advances an `CNT_W`-bit watchdog counter. Re-arming clears only the watchdog counter and leaves the prescaler running. The first step after a restart therefore arrives at an arbitrary phase, and the real timeout can be up to one step (a fraction of 2^-`CNT_W`) shorter than nominal. The prescaler and the counter both freeze while the CPU is stopped or is running from the subsystem clock. They keep running while the CPU is halted.

Control comes through one byte-wide mode register. Bit 4 enables the watchdog, bit 3 selects the expiry action, and bit 7 is the arm/re-arm strobe. Once the block is armed, the enable and action bits cannot change until the block is reset.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous reset, the prescaler and counter are zero, the block is unarmed, both request outputs are low, and `rd_data_o` reads 0.
- R2: A write to the mode register stores bit 4 as enable and bit 3 as action (1 = reset request, 0 = NMI request). `rd_data_o` returns enable at bit 4, action at bit 3, and 0 in every other bit. Bit 7 always reads back as 0.
- R3: A write with bit 7 set arms the block only if bit 4 is also 1 in the same write. A write with bit 7 set and bit 4 clear leaves the block unarmed and produces no request.
- R4: Period code c (0 to 6) gives a nominal timeout of 2^(BASE_EXP+c) main clocks, and code 7 gives 2^(BASE_EXP+8).
- R5: The counter steps once each time the prescaler bit at position (timeout exponent − CNT_W − 1) goes from 0 to 1. Expiry happens on the 2^CNT_W-th step after the last arm.
- R6: Any later write with bit 7 set clears the counter to 0 and restarts the interval. The prescaler is not cleared.
- R7: On expiry, exactly one of `rst_req_o` or `nmi_req_o` goes high for one cycle, as chosen by the action bit. The counter then restarts from 0, so a missing re-arm produces repeated requests one full interval apart.
- R8: A re-arm write in the same cycle as the expiring step wins. No request is issued, and the next interval starts from that write.
- R9: After arming, writes do not change the enable or action bits until a reset.
- R10: While `stop_i` or `subclk_i` is high, the prescaler and counter hold their values. `halt_i` has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main system clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_data_i | input | 8 | Mode register write data |
| period_sel_i | input | 3 | Timeout period code |
| halt_i | input | 1 | CPU halted indication (counting continues) |
| stop_i | input | 1 | CPU stopped indication (counting frozen) |
| subclk_i | input | 1 | CPU runs on the subsystem clock (counting frozen) |
| rd_data_o | output | 8 | Mode register read-back |
| rst_req_o | output | 1 | One-cycle system reset request |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request |

## Verification
A re-arm write and the expiring counter step can land in the same cycle. The bench provokes this case on purpose. It keeps its own copy of the prescaler count, computes the edge on which the final step falls, and drives the re-arm write onto exactly that edge. It then judges the outcome on two points: no request appears in the following cycle, and the next request arrives exactly one interval measured from the colliding write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int RUN_BIT = 7;
    localparam int EN_BIT  = 4;
    localparam int ACT_BIT = 3;

    typedef enum logic {
        ACT_NMI   = 1'b0,
        ACT_RESET = 1'b1
    } wdog_act_e;

    typedef struct packed {
        logic      started;
        logic      en;
        wdog_act_e act;
    } wdog_mode_t;

    // timeout exponent for a period code: one step per code, a double step on the last
    function automatic int exp_of(input int code, input int base_exp);
        return (code == 7) ? base_exp + 8 : base_exp + code;
    endfunction

    // prescaler bit whose rising edge advances the watchdog counter
    function automatic int tap_of(input int code, input int base_exp, input int cnt_w);
        return exp_of(code, base_exp) - cnt_w - 1;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PW = 11
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          adv_i,
    output logic [PW-1:0] presc_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            presc_o <= '0;
        else if (adv_i)
            presc_o <= presc_o + PW'(1);
    end

    assert_freeze_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |=> $stable(presc_o));

endmodule

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 11,
    parameter int CNT_W    = 8,
    parameter int PW       = BASE_EXP + 8 - CNT_W
) (
    input  logic [PW-1:0] presc_i,
    input  logic [2:0]    code_i,
    input  logic          adv_i,
    output logic          tick_o
);

    logic [7:0] hit;

    // hit[c]: the next prescaler step raises the tap bit for code c
    for (genvar c = 0; c < 8; c++) begin : g_tap
        localparam int T = tap_of(c, BASE_EXP, CNT_W);
        if (T == 0) begin : g_lsb
            assign hit[c] = ~presc_i[0];
        end else begin : g_upper
            assign hit[c] = ~presc_i[T] & (&presc_i[T-1:0]);
        end
    end

    assign tick_o = hit[code_i] & adv_i;

endmodule

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
    import wdog_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output wdog_mode_t mode_o,
    output logic       restart_o,
    output logic [7:0] rd_data_o
);

    wdog_mode_t q;
    logic       run_wr;
    logic       en_eff;
    logic       unused_bits;

    assign unused_bits = ^{wr_data_i[6:5], wr_data_i[2:0]};

    always_comb begin
        run_wr    = wr_en_i && wr_data_i[RUN_BIT];
        en_eff    = q.started ? q.en : wr_data_i[EN_BIT];
        restart_o = run_wr && en_eff;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else if (wr_en_i && !q.started) begin
            q.en      <= wr_data_i[EN_BIT];
            q.act     <= wdog_act_e'(wr_data_i[ACT_BIT]);
            q.started <= run_wr && wr_data_i[EN_BIT];
        end
    end

    always_comb begin
        rd_data_o          = '0;
        rd_data_o[EN_BIT]  = q.en;
        rd_data_o[ACT_BIT] = q.act;
    end

    assign mode_o = q;

    assert_lock_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        q.started |=> (q.started && $stable(q.en) && $stable(q.act)));

    assert_run_needs_en_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_data_i[RUN_BIT] && !wr_data_i[EN_BIT] && !q.started) |=> !q.started);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      tick_i,
    input  logic      active_i,
    input  logic      restart_i,
    input  wdog_act_e act_i,
    output logic      rst_req_o,
    output logic      nmi_req_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q     <= '0;
            rst_req_o <= 1'b0;
            nmi_req_o <= 1'b0;
        end else begin
            rst_req_o <= 1'b0;
            nmi_req_o <= 1'b0;
            if (restart_i) begin
                cnt_q <= '0;
            end else if (active_i && tick_i) begin
                if (cnt_q == CNT_MAX) begin
                    cnt_q <= '0;
                    if (act_i == ACT_RESET)
                        rst_req_o <= 1'b1;
                    else
                        nmi_req_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !active_i |=> !(rst_req_o || nmi_req_o));

    assert_restart_wins_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> !(rst_req_o || nmi_req_o));

    assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (rst_req_o || nmi_req_o) |=> !(rst_req_o || nmi_req_o));

    assert_route_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |-> (!nmi_req_o && act_i == ACT_RESET));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int BASE_EXP = 11
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic [2:0] period_sel_i,
    input  logic       halt_i,
    input  logic       stop_i,
    input  logic       subclk_i,
    output logic [7:0] rd_data_o,
    output logic       rst_req_o,
    output logic       nmi_req_o
);

    localparam int PRE_W = BASE_EXP + 8 - CNT_W;

    logic             adv;
    logic [PRE_W-1:0] presc;
    logic             tick;
    logic             restart;
    wdog_mode_t       mode;
    logic             unused_halt;

    // halt deliberately takes no part in the freeze condition
    assign unused_halt = halt_i;
    assign adv         = !(stop_i || subclk_i);

    wdog_prescaler #(.PW(PRE_W)) u_presc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (adv),
        .presc_o (presc)
    );

    wdog_tick_sel #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W), .PW(PRE_W)) u_tick (
        .presc_i (presc),
        .code_i  (period_sel_i),
        .adv_i   (adv),
        .tick_o  (tick)
    );

    wdog_mode_reg u_mode (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .mode_o    (mode),
        .restart_o (restart),
        .rd_data_o (rd_data_o)
    );

    wdog_core #(.CNT_W(CNT_W)) u_core (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick),
        .active_i  (mode.started && mode.en),
        .restart_i (restart),
        .act_i     (mode.act),
        .rst_req_o (rst_req_o),
        .nmi_req_o (nmi_req_o)
    );

    assert_halt_runs_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (halt_i && !stop_i && !subclk_i) |=> (presc == $past(presc) + PRE_W'(1)));

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 3;
    localparam int BX         = 5;
    localparam int MAX_CYC    = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] code = '0;
    logic       halt = 1'b0;
    logic       stop = 1'b0;
    logic       subclk = 1'b0;
    logic [7:0] rd;
    logic       rreq;
    logic       nreq;

    int  pm;
    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench mirror of the prescaler count, from R1 and R10
    always @(posedge clk) begin
        if (rst) pm <= 0;
        else if (!(stop || subclk)) pm <= pm + 1;
    end

    wdog_timer #(.CNT_W(CW), .BASE_EXP(BX)) u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .period_sel_i (code),
        .halt_i       (halt),
        .stop_i       (stop),
        .subclk_i     (subclk),
        .rd_data_o    (rd),
        .rst_req_o    (rreq),
        .nmi_req_o    (nreq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int period_of(input int c);
        int e;
        e = (c == 7) ? BX + 8 : BX + c;
        return 1 << (e - CW);
    endfunction

    // prescaler value before the edge on which the expiring step lands
    function automatic int deadline(input int w, input int c);
        int p, half, s, q1;
        p    = period_of(c);
        half = p / 2 - 1;
        s    = w + 1;
        q1   = s + ((half - (s % p)) + p) % p;
        return q1 + ((1 << CW) - 1) * p;
    endfunction

    // called at a negedge; w returns the prescaler value before the write edge
    task automatic write(input logic [7:0] d, output int w);
        wr_en   = 1'b1;
        wr_data = d;
        w       = pm;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            if (rreq || nreq) seen++;
            @(negedge clk);
        end
        check(seen == 0, req, "no request while idle", seen, 0);
    endtask

    task automatic run_to(input int target, input string req);
        int seen = 0;
        while (pm != target) begin
            if (rreq || nreq) seen++;
            @(negedge clk);
        end
        check(seen == 0, req, "no request before target", seen, 0);
    endtask

    task automatic expect_exp(input int q, input bit want_rst, input string req);
        run_to(q + 1, req);
        check(rreq == want_rst && nreq == !want_rst, req, "request kind {rst,nmi}",
              int'({rreq, nreq}), int'({want_rst, !want_rst}));
        @(negedge clk);
        check(!rreq && !nreq, "R7", "request lasts one cycle", int'({rreq, nreq}), 0);
    endtask

    initial begin
        int w, w2, q;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(rd == 8'h00, "R1", "readback after reset", rd, 0);
        check(!rreq, "R1", "reset request low", rreq, 0);
        check(!nreq, "R1", "nmi request low", nreq, 0);

        // R3: RUN without enable does not arm
        write(8'h80, w);
        idle_quiet(300, "R3");
        check(rd == 8'h00, "R3", "readback after unarmed RUN", rd, 0);

        // R2/R5: arm in NMI mode, shortest code
        code = 3'd0;
        write(8'h90, w);
        check(rd == 8'h10, "R2", "readback enable, RUN reads 0", rd, 8'h10);
        q = deadline(w, 0);
        expect_exp(q, 1'b0, "R5");

        // R7: repeated request one interval later
        q = q + (1 << CW) * period_of(0);
        expect_exp(q, 1'b0, "R7");

        // R4: sweep the remaining period codes
        for (int c = 1; c < 8; c++) begin
            code = 3'(c);
            write(8'h80, w);
            q = deadline(w, c);
            expect_exp(q, 1'b0, "R4");
        end

        // R6: re-arm mid-interval postpones expiry
        code = 3'd2;
        write(8'h80, w);
        idle_quiet(period_of(2) * 5, "R6");
        write(8'h80, w2);
        q = deadline(w2, 2);
        expect_exp(q, 1'b0, "R6");

        // R8: re-arm on the expiring edge suppresses the request
        code = 3'd1;
        write(8'h80, w);
        q = deadline(w, 1);
        run_to(q, "R8");
        write(8'h80, w2);
        check(!rreq && !nreq, "R8", "no request on colliding re-arm", int'({rreq, nreq}), 0);
        q = deadline(w2, 1);
        expect_exp(q, 1'b0, "R8");

        // R9: enable/action locked after arming
        write(8'h08, w);
        check(rd == 8'h10, "R9", "mode bits locked", rd, 8'h10);
        write(8'h80, w);
        q = deadline(w, 1);
        expect_exp(q, 1'b0, "R9");

        // R10: stop freezes counting
        code = 3'd3;
        write(8'h80, w);
        q = deadline(w, 3);
        stop = 1'b1;
        idle_quiet(400, "R10");
        stop = 1'b0;
        expect_exp(q, 1'b0, "R10");

        // R10: subsystem clock freezes counting
        write(8'h80, w);
        q = deadline(w, 3);
        subclk = 1'b1;
        idle_quiet(400, "R10");
        subclk = 1'b0;
        expect_exp(q, 1'b0, "R10");

        // R10: halt does not affect counting
        halt = 1'b1;
        write(8'h80, w);
        q = deadline(w, 3);
        expect_exp(q, 1'b0, "R10");
        halt = 1'b0;

        // R1/R2/R7: reset, then arm in reset-request mode
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rd == 8'h00, "R1", "readback after second reset", rd, 0);
        code = 3'd0;
        write(8'h98, w);
        check(rd == 8'h18, "R2", "readback enable and action", rd, 8'h18);
        q = deadline(w, 0);
        expect_exp(q, 1'b1, "R7");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", MAX_CYC, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule